// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Update-Status Logic

This block holds the control and status side of a real-time clock: a rate/divider register, a control register, a clear-on-read interrupt flag register and a read-only validity register, all reached through a byte-wide register port at indices 10 to 13. A time-base enable pulse (one per 32.768 kHz period) drives a divider chain. The chain produces the periodic-interrupt events, an optional square wave and a once-per-second update strobe for the calendar logic that sits next to the block.

Each update is framed by an update-in-progress flag. The flag rises a fixed number of time-base ticks before the strobe and stays high until the update window closes, at which point the update-finished flag is set. An inhibit bit in the control register stops new updates from starting. Periodic, alarm and update-finished flags always latch. Their enables gate only the summary bit and the interrupt line.

Top module: `rtc_ctl_status`

## Requirements
- R1: After reset, indices 10, 11 and 12 read 0x00, index 13 reads the validity input in bit 7 with zeros below it, and `irq`, `sqw` and `upd_strobe` are low.
- R2: A read issued in one cycle returns its data on `reg_rdata` in the next cycle. Index 10 bits [6:0] and all of index 11 read back what was written, and bit 7 of index 10 ignores writes. Writes to indices 12 and 13 have no effect, and any other index reads 0x00. `mode_bits` reflects index 11 bits [2:0].
- R3: With index 10 bits [6:4] = 010, a rate code c in bits [3:0] from 1 to 15 produces a periodic event every 2^(c-1) time-base ticks. Code 0 produces none.
- R4: `sqw` toggles on each periodic event while index 11 bit 3 is set and the rate code is nonzero. Otherwise it is held low.
- R5: In index 12, bit 6 (periodic), bit 5 (alarm, set by a pulse on `alarm_hit`) and bit 4 (update finished) latch whatever the enables are.
- R6: Index 12 bit 7 is set exactly when a latched flag has its enable set: index 11 bit 6 for periodic, bit 5 for alarm and bit 4 for update finished. `irq` is active-high and equals that bit.
- R7: A read of index 12 returns the value held before the access and clears all flags. A flag event that occurs in the same cycle as the read stays latched.
- R8: Index 10 bit 7 (update in progress) goes high LEAD ticks before `upd_strobe`. It stays high for UPD_LEN ticks after the strobe and falls in the cycle in which the update-finished flag is set.
- R9: `upd_strobe` pulses for one cycle when the divider wraps after 2^DIV_W ticks. Divider code 110 or 111 holds the count at zero, and the chain advances only under code 010.
- R10: While index 11 bit 7 is set, no update starts, `upd_strobe` stays low and update-in-progress is held low. An update already under way still completes and sets its flag.
- R11: Index 13 bit 7 follows the `ram_valid` input, and index 13 cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base enable, one pulse per 32.768 kHz period |
| reg_addr | input | ADDR_W | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| alarm_hit | input | 1 | One-cycle pulse from the calendar alarm compare |
| ram_valid | input | 1 | Validity status for index 13 bit 7 |
| irq | output | 1 | Active-high interrupt request |
| sqw | output | 1 | Square-wave output |
| upd_strobe | output | 1 | One-cycle pulse at the start of each update |
| mode_bits | output | 3 | Index 11 bits [2:0] for the calendar logic |

## Verification
The bench keeps `tick` high and counts clock edges, so every result has a fixed edge number. After a chain clear written at edge W, update-in-progress becomes visible after edge W+1+2^DIV_W-1-LEAD, the strobe after edge W+2^DIV_W, and the update-finished flag with `irq` LEAD+UPD_LEN ticks after the flag rose. Read data always shows the state after the edge before the read was captured. Checks therefore sample at the negative edge that follows the edge they predict, and they probe the cycle on each side of every boundary. Periodic intervals are measured as the edge distance between successive `sqw` toggles.

// File: rtl/rtc_cs_pkg.sv
package rtc_cs_pkg;

  localparam int IDX_RATE  = 10;
  localparam int IDX_CTRL  = 11;
  localparam int IDX_FLAG  = 12;
  localparam int IDX_VALID = 13;

  typedef enum logic [1:0] {
    CHAIN_STOP,
    CHAIN_RUN,
    CHAIN_CLEAR
  } chain_mode_e;

  // divider field decode: only 010 runs, 11x clears
  function automatic chain_mode_e chain_decode(input logic [2:0] sel);
    if (sel == 3'b010)       return CHAIN_RUN;
    else if (sel[2:1] == 2'b11) return CHAIN_CLEAR;
    else                     return CHAIN_STOP;
  endfunction

  // low (code-1) bits of the tick count all ones -> one event per 2^(code-1) ticks
  function automatic logic rate_hit(input logic [31:0] cnt, input logic [3:0] code);
    logic [31:0] mask;
    if (code == 4'd0) return 1'b0;
    mask = (32'd1 << (code - 4'd1)) - 32'd1;
    return (cnt & mask) == mask;
  endfunction

endpackage

// File: rtl/rtc_cs_divider.sv
module rtc_cs_divider
  import rtc_cs_pkg::*;
#(
  parameter int DIV_W   = 15,
  parameter int LEAD    = 8,
  parameter int UPD_LEN = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] chain_sel,
  input  logic [3:0] rate_code,
  input  logic       inhibit,
  output logic       pe_evt,
  output logic       upd_strobe,
  output logic       uip,
  output logic       busy,
  output logic       upd_done
);

  localparam logic [DIV_W-1:0] CNT_MAX = '1;
  localparam logic [DIV_W-1:0] LEAD_AT = CNT_MAX - DIV_W'(LEAD);
  localparam int               BW      = $clog2(UPD_LEN + 1);

  chain_mode_e      mode;
  logic             adv;
  logic             sec_evt;
  logic             lead_evt;
  logic [DIV_W-1:0] cnt;
  logic [BW-1:0]    bcnt;

  assign mode     = chain_decode(chain_sel);
  assign adv      = tick && (mode == CHAIN_RUN);
  assign pe_evt   = adv && rate_hit(32'(cnt), rate_code);
  assign sec_evt  = adv && (cnt == CNT_MAX);
  assign lead_evt = adv && (cnt == LEAD_AT);
  assign upd_done = busy && tick && (bcnt == BW'(UPD_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (mode == CHAIN_CLEAR)  cnt <= '0;
    else if (adv)                  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      bcnt <= '0;
    end else if (sec_evt && !inhibit && !busy) begin
      busy <= 1'b1;
      bcnt <= '0;
    end else if (upd_done) begin
      busy <= 1'b0;
    end else if (busy && tick) begin
      bcnt <= bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          uip <= 1'b0;
    else if (upd_done)                                   uip <= 1'b0;
    else if (!busy && (inhibit || mode == CHAIN_CLEAR))  uip <= 1'b0;
    else if ((lead_evt || sec_evt) && !inhibit)          uip <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_strobe <= 1'b0;
    else        upd_strobe <= sec_evt && !inhibit && !busy;
  end

endmodule

// File: rtl/rtc_cs_flags.sv
module rtc_cs_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pe_evt,
  input  logic       alarm_hit,
  input  logic       upd_done,
  input  logic       clr,
  input  logic [2:0] en,
  output logic [2:0] flags,
  output logic       irqf
);

  logic [2:0] set_v;
  assign set_v = {pe_evt, alarm_hit, upd_done};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= '0;
    else if (clr) flags <= set_v;
    else          flags <= flags | set_v;
  end

  assign irqf = |(flags & en);

endmodule

// File: rtl/rtc_cs_sqw.sv
module rtc_cs_sqw (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pe_evt,
  input  logic       sqw_en,
  input  logic [3:0] rate_code,
  output logic       sqw
);

  logic active;
  assign active = sqw_en && (rate_code != 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sqw <= 1'b0;
    else if (!active) sqw <= 1'b0;
    else if (pe_evt)  sqw <= ~sqw;
  end

endmodule

// File: rtl/rtc_ctl_status.sv
module rtc_ctl_status
  import rtc_cs_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DIV_W   = 15,
  parameter int LEAD    = 8,
  parameter int UPD_LEN = 65
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              alarm_hit,
  input  logic              ram_valid,
  output logic              irq,
  output logic              sqw,
  output logic              upd_strobe,
  output logic [2:0]        mode_bits
);

  logic [6:0] rate_q;
  logic [7:0] ctrl_q;
  logic [7:0] rd_mux;

  // named internal events for the bound checker
  logic       pe_w;
  logic       uip_w;
  logic       busy_w;
  logic       done_w;
  logic       inhibit_w;
  logic       clr_w;
  logic       irqf_w;
  logic       sqw_en_w;
  logic [2:0] flags_w;
  logic [2:0] en_w;
  logic [3:0] rate_code_w;

  logic hit_rate, hit_ctrl, hit_flag, hit_valid;
  assign hit_rate  = reg_addr == ADDR_W'(IDX_RATE);
  assign hit_ctrl  = reg_addr == ADDR_W'(IDX_CTRL);
  assign hit_flag  = reg_addr == ADDR_W'(IDX_FLAG);
  assign hit_valid = reg_addr == ADDR_W'(IDX_VALID);

  assign inhibit_w   = ctrl_q[7];
  assign en_w        = ctrl_q[6:4];
  assign sqw_en_w    = ctrl_q[3];
  assign mode_bits   = ctrl_q[2:0];
  assign rate_code_w = rate_q[3:0];
  assign clr_w       = reg_rd && hit_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      ctrl_q <= '0;
    end else if (reg_wr) begin
      if (hit_rate) rate_q <= reg_wdata[6:0];
      if (hit_ctrl) ctrl_q <= reg_wdata;
    end
  end

  rtc_cs_divider #(
    .DIV_W  (DIV_W),
    .LEAD   (LEAD),
    .UPD_LEN(UPD_LEN)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .chain_sel (rate_q[6:4]),
    .rate_code (rate_code_w),
    .inhibit   (inhibit_w),
    .pe_evt    (pe_w),
    .upd_strobe(upd_strobe),
    .uip       (uip_w),
    .busy      (busy_w),
    .upd_done  (done_w)
  );

  rtc_cs_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .pe_evt   (pe_w),
    .alarm_hit(alarm_hit),
    .upd_done (done_w),
    .clr      (clr_w),
    .en       (en_w),
    .flags    (flags_w),
    .irqf     (irqf_w)
  );

  rtc_cs_sqw u_sqw (
    .clk      (clk),
    .rst_n    (rst_n),
    .pe_evt   (pe_w),
    .sqw_en   (sqw_en_w),
    .rate_code(rate_code_w),
    .sqw      (sqw)
  );

  assign irq = irqf_w;

  always_comb begin
    rd_mux = 8'h00;
    if (hit_rate)       rd_mux = {uip_w, rate_q};
    else if (hit_ctrl)  rd_mux = ctrl_q;
    else if (hit_flag)  rd_mux = {irqf_w, flags_w, 4'b0000};
    else if (hit_valid) rd_mux = {ram_valid, 7'b0000000};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= 8'h00;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/rtc_ctl_status_chk.sv
module rtc_ctl_status_chk #(
  parameter int LEAD    = 8,
  parameter int UPD_LEN = 65
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       irq,
  input logic       sqw,
  input logic       upd_strobe,
  input logic       uip,
  input logic       busy,
  input logic       pe_evt,
  input logic       upd_done,
  input logic       inhibit,
  input logic       clr,
  input logic       alarm_hit,
  input logic       sqw_en,
  input logic [3:0] rate_code,
  input logic [2:0] flags
);

  localparam int LIM = LEAD + UPD_LEN;

  logic [15:0] uip_ticks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     uip_ticks <= '0;
    else if (!uip)  uip_ticks <= '0;
    else if (tick)  uip_ticks <= uip_ticks + 1'b1;
  end

  // R8: the strobe only ever occurs inside the update-in-progress window
  p_strobe_in_uip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> uip);

  // R8: the window never exceeds lead plus update length in ticks
  p_uip_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uip_ticks <= 16'(LIM));

  // R10: no strobe follows a cycle with updates inhibited
  p_strobe_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> !$past(inhibit));

  // R10: inhibit with no update running keeps the flag low
  p_uip_low_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !busy) |=> !uip);

  // R4: square wave held low when disabled or rate is off
  p_sqw_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sqw_en && rate_code != 4'd0) |=> !sqw);

  // R4: square wave moves only on a periodic event
  p_sqw_moves_on_pe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sqw_en && rate_code != 4'd0 && !pe_evt) |=> $stable(sqw));

  // R5: a periodic event always latches its flag
  p_pf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pe_evt |=> flags[2]);

  // R7: a flag read with no concurrent event leaves all flags clear
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !pe_evt && !alarm_hit && !upd_done) |=> (flags == 3'b000));

  // R6: no interrupt without a latched flag
  p_irq_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 3'b000) |-> !irq);

endmodule

bind rtc_ctl_status rtc_ctl_status_chk #(
  .LEAD   (LEAD),
  .UPD_LEN(UPD_LEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .irq       (irq),
  .sqw       (sqw),
  .upd_strobe(upd_strobe),
  .uip       (uip_w),
  .busy      (busy_w),
  .pe_evt    (pe_w),
  .upd_done  (done_w),
  .inhibit   (inhibit_w),
  .clr       (clr_w),
  .alarm_hit (alarm_hit),
  .sqw_en    (sqw_en_w),
  .rate_code (rate_code_w),
  .flags     (flags_w)
);

// File: tb/rtc_ctl_status_bench.sv
module rtc_ctl_status_bench;

  localparam int ADDR_W  = 4;
  localparam int DIV_W   = 15;
  localparam int LEAD    = 8;
  localparam int UPD_LEN = 65;
  localparam int MAXV    = (1 << DIV_W) - 1;
  localparam int SECOND  = 1 << DIV_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b1;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [7:0]        reg_wdata = '0;
  logic [7:0]        reg_rdata;
  logic              alarm_hit = 1'b0;
  logic              ram_valid = 1'b1;
  logic              irq, sqw, upd_strobe;
  logic [2:0]        mode_bits;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_ctl_status #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .LEAD(LEAD), .UPD_LEN(UPD_LEN)
  ) u_rtc_ctl_status (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_hit(alarm_hit), .ram_valid(ram_valid),
    .irq(irq), .sqw(sqw), .upd_strobe(upd_strobe), .mode_bits(mode_bits)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // all tasks start and end at a negative edge
  task automatic wr(input int a, input int d);
    reg_addr = ADDR_W'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = ADDR_W'(a); reg_rd = 1'b1;
    @(negedge clk);
    d = int'(reg_rdata);
    reg_rd = 1'b0;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic pulse_alarm();
    alarm_hit = 1'b1;
    @(negedge clk);
    alarm_hit = 1'b0;
  endtask

  initial begin
    int d, w, s2, s3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", irq, 0);
    check("R1 sqw", sqw, 0);
    check("R1 strobe", upd_strobe, 0);
    rd(10, d); check("R1 idx10", d, 8'h00);
    rd(11, d); check("R1 idx11", d, 8'h00);
    rd(12, d); check("R1 idx12", d, 8'h00);
    rd(13, d); check("R1 idx13", d, 8'h80);

    // R11: validity follows input, not writable
    ram_valid = 1'b0;
    rd(13, d); check("R11 valid low", d, 8'h00);
    wr(13, 8'hFF);
    rd(13, d); check("R11 write ignored", d, 8'h00);

    // R2: register access
    wr(11, 8'hA5);
    rd(11, d); check("R2 idx11 readback", d, 8'hA5);
    check("R2 mode_bits", int'(mode_bits), 3'b101);
    wr(10, 8'hFF);
    rd(10, d); check("R2 idx10 bit7 read-only", d, 8'h7F);
    wr(12, 8'hFF);
    rd(12, d); check("R2 idx12 write ignored", d, 8'h00);
    rd(5, d);  check("R2 unused index", d, 8'h00);

    // R3 R4: periodic rate sweep via square-wave toggle spacing (inhibit on)
    wr(11, 8'h88);
    for (int c = 1; c <= 13; c++) begin
      logic prev;
      int t0, guard;
      wr(10, 8'h20 | c);
      prev = sqw; guard = 0;
      while (sqw == prev && guard < (4 << c)) begin @(negedge clk); guard++; end
      t0 = cyc; prev = sqw; guard = 0;
      while (sqw == prev && guard < (4 << c)) begin @(negedge clk); guard++; end
      check($sformatf("R3 period code %0d", c), cyc - t0, 1 << (c - 1));
    end
    begin
      int hi;
      wr(10, 8'h20);
      @(negedge clk);
      hi = 0;
      for (int k = 0; k < 64; k++) begin @(negedge clk); hi |= int'(sqw); end
      check("R4 sqw low at rate 0", hi, 0);
      wr(11, 8'h80);
      wr(10, 8'h23);
      @(negedge clk);
      hi = 0;
      for (int k = 0; k < 64; k++) begin @(negedge clk); hi |= int'(sqw); end
      check("R4 sqw low when disabled", hi, 0);
    end

    // R5 R6 R7: periodic flag latches without enable, cleared by read
    wr(10, 8'h20);
    rd(12, d);
    wr(10, 8'h23);
    repeat (10) @(negedge clk);
    wr(10, 8'h20);
    check("R6 irq off without enable", irq, 0);
    rd(12, d); check("R5 pf latched", d, 8'h40);
    rd(12, d); check("R7 cleared by read", d, 8'h00);

    wr(11, 8'hC0);
    wr(10, 8'h23);
    repeat (10) @(negedge clk);
    wr(10, 8'h20);
    check("R6 irq with pie", irq, 1);
    rd(12, d); check("R6 summary bit", d, 8'hC0);
    check("R7 irq drops after read", irq, 0);

    // R5 R6: alarm flag
    wr(11, 8'h80);
    pulse_alarm();
    check("R6 irq off alarm disabled", irq, 0);
    rd(12, d); check("R5 af latched", d, 8'h20);
    wr(11, 8'hA0);
    pulse_alarm();
    check("R6 irq alarm enabled", irq, 1);
    rd(12, d); check("R6 alarm summary", d, 8'hA0);
    check("R7 irq after alarm read", irq, 0);

    // R7: event in the same cycle as the read survives
    wr(11, 8'h80);
    reg_addr = ADDR_W'(12); reg_rd = 1'b1; alarm_hit = 1'b1;
    @(negedge clk);
    d = int'(reg_rdata); reg_rd = 1'b0; alarm_hit = 1'b0;
    check("R7 read returns prior value", d, 8'h00);
    rd(12, d); check("R7 concurrent event kept", d, 8'h20);

    // R8 R9: timed update after a chain clear
    wr(10, 8'h60);
    wr(11, 8'h10);
    rd(12, d);
    w = cyc + 1;
    wr(10, 8'h20);
    wait_to(w + MAXV - LEAD);
    rd(10, d); check("R8 uip before lead", d, 8'h20);
    rd(10, d); check("R8 uip at lead", d, 8'hA0);
    wait_to(w + MAXV);
    check("R9 no strobe early", upd_strobe, 0);
    @(negedge clk);
    check("R9 strobe at wrap", upd_strobe, 1);
    @(negedge clk);
    check("R9 strobe one cycle", upd_strobe, 0);
    wait_to(w + MAXV + UPD_LEN);
    check("R8 uf not yet", irq, 0);
    rd(10, d); check("R8 uip at window end", d, 8'hA0);
    check("R8 uf set", irq, 1);
    rd(10, d); check("R8 uip falls with uf", d, 8'h20);
    rd(12, d); check("R5 uf latched", d, 8'h90);

    // R10: inhibit blocks the next update
    s2 = w + MAXV + 1 + SECOND;
    wr(11, 8'h90);
    wait_to(s2 - LEAD);
    rd(10, d); check("R10 uip held low", d, 8'h20);
    wait_to(s2);
    check("R10 no strobe", upd_strobe, 0);
    wait_to(s2 + UPD_LEN + 2);
    check("R10 no uf irq", irq, 0);
    rd(12, d); check("R10 no flag", d, 8'h00);

    // R10: update already running completes
    s3 = s2 + SECOND;
    wr(11, 8'h10);
    wait_to(s3 + 2);
    wr(11, 8'h90);
    wait_to(s3 + UPD_LEN - 1);
    check("R10 running not done", irq, 0);
    @(negedge clk);
    check("R10 running completes", irq, 1);
    rd(12, d); check("R10 uf after inhibit", d, 8'h90);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule